// File: doc/BRIEF.md
# Modulator Coefficient Phase Sequencer

The block turns the index of a 16-state synchronisation sequencer into the per-sample coefficient of a quarter-rate digital modulator. Once per DAC clock it produces one step of the repeating pattern +1, 0, -1, 0, and an applied phase that shows where in that pattern the current sample falls. A 3-bit phase offset chooses which step of the pattern lines up with sequencer state zero. Changing this offset rotates the carrier in quarter-cycle steps.

A new offset arrives on a write strobe at any point in the 16-state cycle. It is held in a shadow register and does not take effect until the next sample at which the state index is zero. If several devices receive the same write in one group transfer, they all switch to the new alignment on the same cycle. A second write before that boundary replaces the value that is waiting. When the devices follow a master's sequencer directly, their sequencer indices already agree, so no offset write is needed.

Top module: `mod_coef_seq`

## Requirements
- R1: While rst_ni is low, and on the first sample after it, phase_o is 0 and coef_o is 2'b01. Both the active offset and the pending offset reset to 0.
- R2: One clock after state_i is sampled, phase_o equals (state_i + active offset) mod 4.
- R3: coef_o is two's complement with 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1. Phase 0 gives +1, phase 1 gives 0, phase 2 gives -1 and phase 3 gives 0.
- R4: A write (adj_wr_i high, value on adj_i) does not change the outputs until the first later sample with state_i == 0. From that sample on, the written value is the active offset.
- R5: If a second write arrives before the commit sample, its value replaces the pending one, and only the last value is applied.
- R6: A write in the same cycle as a state-zero sample is not applied at that sample. It becomes active at the next state-zero sample.
- R7: Offset values 4 to 7 have the same effect as values 0 to 3, because only the offset modulo 4 matters.
- R8: If no write is pending, passing through state zero leaves the active offset unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | DAC update clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_i | input | 4 | Index of the synchronisation sequencer, 0 to 15 |
| adj_i | input | 3 | New phase offset, captured when adj_wr_i is high |
| adj_wr_i | input | 1 | Write strobe for the phase offset |
| coef_o | output | 2 | Modulator coefficient, two's complement |
| phase_o | output | 2 | Applied phase, (state + offset) mod 4 |

## Verification
Both outputs are registered once. For each state index, its phase and coefficient are due on the first rising edge after that index is applied. The bench drives each index on a falling edge and compares both outputs at the next falling edge, after exactly one rising edge. A committed offset appears in that same one-cycle window for the state-zero index, and a write shows no effect on the outputs until then. The bench therefore follows every write with a run of samples that crosses at least one state-zero boundary, and it checks each of those samples.

// File: rtl/mod_seq_pkg.sv
package mod_seq_pkg;
  localparam int SEQ_LEN = 4;
  localparam int PH_W    = $clog2(SEQ_LEN);

  typedef logic signed [1:0] coef_t;

  localparam coef_t COEF_POS  = 2'sb01;
  localparam coef_t COEF_ZERO = 2'sb00;
  localparam coef_t COEF_NEG  = 2'sb11;

  // quarter-rate carrier: +1, 0, -1, 0
  function automatic coef_t coef_of(input logic [PH_W-1:0] ph);
    coef_t c;
    unique case (ph)
      2'd0:    c = COEF_POS;
      2'd2:    c = COEF_NEG;
      default: c = COEF_ZERO;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mod_adj_shadow.sv
module mod_adj_shadow #(
  parameter int STATE_W = 4,
  parameter int ADJ_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] state_i,
  input  logic [ADJ_W-1:0]   adj_i,
  input  logic               adj_wr_i,
  output logic [ADJ_W-1:0]   adj_eff_o
);
  logic [ADJ_W-1:0] shadow_q, active_q;
  logic             pend_q;
  logic             at_zero, commit;

  assign at_zero = (state_i == '0);
  assign commit  = at_zero & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (commit) active_q <= shadow_q;
      if (adj_wr_i) begin
        shadow_q <= adj_i;
        pend_q   <= 1'b1;
      end else if (commit) begin
        pend_q <= 1'b0;
      end
    end
  end

  // committing value is used for the state-zero sample itself
  assign adj_eff_o = commit ? shadow_q : active_q;

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_commit_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && active_q != $past(active_q)) |-> ($past(state_i) == '0));

  p_overwrite_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_wr_i |=> (pend_q && shadow_q == $past(adj_i)));

  p_wr_zero_defer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_wr_i && at_zero && !pend_q) |=> $stable(active_q));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> $stable(active_q));
endmodule

// File: rtl/mod_phase_gen.sv
module mod_phase_gen
  import mod_seq_pkg::*;
#(
  parameter int STATE_W = 4,
  parameter int ADJ_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] state_i,
  input  logic [ADJ_W-1:0]   adj_eff_i,
  output logic [PH_W-1:0]    phase_o,
  output coef_t              coef_o
);
  logic [PH_W-1:0] ph_d;

  // only the low bits survive mod SEQ_LEN
  assign ph_d = PH_W'(state_i) + PH_W'(adj_eff_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= '0;
      coef_o  <= COEF_POS;
    end else begin
      phase_o <= ph_d;
      coef_o  <= coef_of(ph_d);
    end
  end

  p_coef_odd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[0] |-> (coef_o == COEF_ZERO));

  p_coef_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |-> (coef_o == (phase_o[1] ? COEF_NEG : COEF_POS)));
endmodule

// File: rtl/mod_coef_seq.sv
module mod_coef_seq
  import mod_seq_pkg::*;
#(
  parameter int STATE_W = 4,
  parameter int ADJ_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] state_i,
  input  logic [ADJ_W-1:0]   adj_i,
  input  logic               adj_wr_i,
  output logic signed [1:0]  coef_o,
  output logic [PH_W-1:0]    phase_o
);
  logic [ADJ_W-1:0] adj_eff;

  mod_adj_shadow #(.STATE_W(STATE_W), .ADJ_W(ADJ_W)) u_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_i),
    .adj_i     (adj_i),
    .adj_wr_i  (adj_wr_i),
    .adj_eff_o (adj_eff)
  );

  mod_phase_gen #(.STATE_W(STATE_W), .ADJ_W(ADJ_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_i),
    .adj_eff_i (adj_eff),
    .phase_o   (phase_o),
    .coef_o    (coef_o)
  );

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  // consecutive non-zero indices with no write: phase advances by one
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && state_i != '0 && !$past(adj_wr_i) && $past(state_i) != '0
     && state_i == $past(state_i) + 1'b1) |=> (phase_o == $past(phase_o) + 1'b1));
endmodule

// File: tb/mod_coef_seq_tb.sv
module mod_coef_seq_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] state_i = '0;
  logic [2:0] adj_i = '0;
  logic       adj_wr_i = 1'b0;
  logic signed [1:0] coef_o;
  logic [1:0] phase_o;

  int total = 0;
  int bad = 0;
  int st = 0;
  int m_active = 0, m_shadow = 0;
  bit m_pend = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mod_coef_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .state_i(state_i),
    .adj_i(adj_i), .adj_wr_i(adj_wr_i),
    .coef_o(coef_o), .phase_o(phase_o)
  );

  function automatic logic [1:0] exp_coef(input int ph);
    case (ph)
      0: return 2'b01;
      2: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input string tag, input int exp_ph);
    total++;
    if (phase_o !== 2'(exp_ph) || coef_o !== exp_coef(exp_ph)) begin
      bad++;
      $display("FAIL %s: phase=%0d coef=%b expected phase=%0d coef=%b",
               tag, phase_o, coef_o, exp_ph, exp_coef(exp_ph));
    end
  endtask

  // drive one index (and optional write) at negedge, check one clock later
  task automatic step(input string tag, input bit wr, input int adj);
    int eff, ph;
    state_i  = 4'(st);
    adj_wr_i = wr;
    adj_i    = 3'(adj);
    eff = (st == 0 && m_pend) ? m_shadow : m_active;
    ph  = (st + eff) % 4;
    if (st == 0 && m_pend) begin m_active = m_shadow; m_pend = 0; end
    if (wr) begin m_shadow = adj; m_pend = 1; end
    @(posedge clk);
    @(negedge clk);
    adj_wr_i = 1'b0;
    check(tag, ph);
    st = (st + 1) % 16;
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 0);
  endtask

  task automatic goto(input string tag, input int target);
    while (st != target) step(tag, 1'b0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 during reset", 0);
    rst_ni = 1'b1;
    st = 0;
    step("R1 first sample", 1'b0, 0);
  endtask

  task automatic t_free_run();
    run("R2/R3 offset 0", 32);
  endtask

  task automatic t_deferred();
    goto("R4 pre", 5);
    step("R4 write", 1'b1, 1);
    run("R4 before/after zero", 24);
    goto("R4 pre2", 9);
    step("R4 write 3", 1'b1, 3);
    run("R4 offset 3", 20);
  endtask

  task automatic t_overwrite();
    goto("R5 pre", 3);
    step("R5 first write", 1'b1, 2);
    step("R5 second write", 1'b1, 1);
    run("R5 last wins", 20);
  endtask

  task automatic t_coincident();
    goto("R6 pre", 0);
    step("R6 write at zero", 1'b1, 2);
    run("R6 not yet", 15);
    run("R6 applied", 8);
  endtask

  task automatic t_alias();
    goto("R7 pre", 7);
    step("R7 write 6", 1'b1, 6);
    run("R7 alias of 2", 20);
    goto("R7 pre2", 2);
    step("R7 write 5", 1'b1, 5);
    run("R7 alias of 1", 20);
  endtask

  task automatic t_hold();
    run("R8 no write", 40);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_deferred();
    t_overwrite();
    t_coincident();
    t_alias();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule